// File: doc/BRIEF.md
# Field-Described Control and Status Register Bank

This block is a small memory-mapped bank of 32-bit registers that software reaches over a plain native bus: a word address, a write strobe with write data, and a read strobe whose data comes back on the next cycle. Every register is put together from a list of fields kept in a package table. Each entry gives the register the field belongs to, its access kind, its width, its reset value and whether a hardware signal drives it. Bit positions are not written by hand. The package works them out by packing the fields of each register from bit 0 upward, in the order the table lists them.

Four access kinds exist. A constant or status field is read-only. A configuration field can be read and written. A sticky event field latches hardware events and clears when software reads it. A command field can only be written, and writing a 1 to it fires a pulse that lasts one cycle. The sticky fields of the designated event register are ORed together into an interrupt line. A bus master that uses byte addresses reaches this bank by dropping its two low address bits.

The default table gives four registers at word addresses 0 to 3:
- **Address 0** holds a 32-bit identification constant.
- **Address 1** holds a control word: a hold bit that resets to 1, a 4-bit gain that resets to 5, and an 8-bit live status input.
- **Address 2** holds two sticky event bits that feed the interrupt.
- **Address 3** holds two command pulses and a mode bit.

Addresses 4 to 7 are not mapped.

Top module: `field_reg_bank`

## Requirements
- R1: A read of address 0 returns the constant 0x6169616D, and no hardware signal can change it.
- R2: Read data appears on `reg_rdata` in the cycle after `reg_ren` is sampled high. In every cycle that follows a cycle with no read strobe, `reg_rdata` is 0.
- R3: After reset, `core_hold` is 1, `gain` is 5 and `narrow_mode` is 0. A write to a read-write field shows up on its output in the cycle after the write. Without a write, the field keeps its value.
- R4: Fields are packed from bit 0 in the order they are listed. Address 1 reads as {status[7:0] at bits 12:5, gain at bits 4:1, hold at bit 0}. Address 2 has event 0 at bit 0 and event 1 at bit 1. Address 3 has start at bit 0, stop at bit 1 and the mode bit at bit 2.
- R5: Read-only fields ignore writes. The status field returns the value `status_in` had in the cycle the read strobe was sampled.
- R6: A sticky bit becomes 1 in the cycle after its `event_in` bit is high. It stays at 1 after the input falls, until a read of address 2.
- R7: A read of address 2 returns the sticky bits and then clears them. A bit whose event input is high in the same cycle as the read stays at 1.
- R8: Writing 1 to bit 0 or bit 1 of address 3 drives `start_pulse` or `stop_pulse` high for exactly the one cycle after the write. Writing 0 produces no pulse. Both bits read back as 0.
- R9: `irq` is high exactly while at least one sticky bit of address 2 is set.
- R10: Reads of addresses 4 to 7 return 0. Writes to those addresses change no output and no readable field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Word address |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_ren | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| status_in | input | 8 | Live status shown in the control word |
| event_in | input | 2 | Event inputs of the sticky bits |
| core_hold | output | 1 | Hold control, resets to 1 |
| gain | output | 4 | Gain setting |
| narrow_mode | output | 1 | Mode bit |
| start_pulse | output | 1 | One-cycle start command |
| stop_pulse | output | 1 | One-cycle stop command |
| irq | output | 1 | OR of the pending sticky bits |

## Verification
A configuration field that latched a wrong value would show up on its dedicated output in the very next cycle, without any bus read. A sticky field that lost an event, or failed to clear, would show up on `irq` within one cycle and on the next read of the event register. Packing errors, a wrong reset constant or decoding of an unmapped address only become visible through a read, so the bench reads every register at least once under distinct data patterns. It does so while a behavioural model checks every output on every clock.

// File: rtl/frb_pkg.sv
package frb_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int NUM_REGS   = 4;
    localparam int NUM_FIELDS = 9;
    localparam int IRQ_REG    = 2;

    typedef enum logic [1:0] {
        ACC_RO,
        ACC_RW,
        ACC_STICKY,
        ACC_PULSE
    } acc_e;

    typedef struct packed {
        acc_e        acc;
        logic        hw;       // a hardware input drives a read-only field
        logic [7:0]  reg_idx;
        logic [6:0]  width;
        logic [31:0] rst;
    } fdesc_t;

    // Field table: order inside one register sets the bit order (LSB first).
    function automatic fdesc_t field_desc(input int idx);
        fdesc_t d;
        d = '{acc: ACC_RO, hw: 1'b0, reg_idx: 8'd0, width: 7'd1, rst: 32'd0};
        case (idx)
            0: d = '{acc: ACC_RO,     hw: 1'b0, reg_idx: 8'd0, width: 7'd32, rst: 32'h6169_616d};
            1: d = '{acc: ACC_RW,     hw: 1'b0, reg_idx: 8'd1, width: 7'd1,  rst: 32'd1};
            2: d = '{acc: ACC_RW,     hw: 1'b0, reg_idx: 8'd1, width: 7'd4,  rst: 32'd5};
            3: d = '{acc: ACC_RO,     hw: 1'b1, reg_idx: 8'd1, width: 7'd8,  rst: 32'd0};
            4: d = '{acc: ACC_STICKY, hw: 1'b1, reg_idx: 8'd2, width: 7'd1,  rst: 32'd0};
            5: d = '{acc: ACC_STICKY, hw: 1'b1, reg_idx: 8'd2, width: 7'd1,  rst: 32'd0};
            6: d = '{acc: ACC_PULSE,  hw: 1'b0, reg_idx: 8'd3, width: 7'd1,  rst: 32'd0};
            7: d = '{acc: ACC_PULSE,  hw: 1'b0, reg_idx: 8'd3, width: 7'd1,  rst: 32'd0};
            8: d = '{acc: ACC_RW,     hw: 1'b0, reg_idx: 8'd3, width: 7'd1,  rst: 32'd0};
            default: d = '{acc: ACC_RO, hw: 1'b0, reg_idx: 8'd0, width: 7'd1, rst: 32'd0};
        endcase
        return d;
    endfunction

    // Bit position of a field: sum of the widths listed before it in its register.
    function automatic int field_lsb(input int idx);
        int sum;
        sum = 0;
        for (int j = 0; j < idx; j++) begin
            if (field_desc(j).reg_idx == field_desc(idx).reg_idx)
                sum += int'(field_desc(j).width);
        end
        return sum;
    endfunction

endpackage

// File: rtl/frb_field.sv
module frb_field
    import frb_pkg::*;
#(
    parameter acc_e           ACC = ACC_RW,
    parameter int             W   = 1,
    parameter logic [W-1:0]   RST = '0,
    parameter bit             HW  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         rd_hit,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_in,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] hw_out
);

    typedef struct packed {
        logic [W-1:0] val;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (ACC)
            ACC_RW:     if (wr_hit) st_d.val = wdata;
            ACC_STICKY: st_d.val = rd_hit ? hw_in : (st_q.val | hw_in);
            ACC_PULSE:  st_d.val = wr_hit ? wdata : '0;
            default:    st_d.val = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: RST};
        else        st_q <= st_d;
    end

    always_comb begin
        rd_val = '0;
        hw_out = '0;
        case (ACC)
            ACC_RW: begin
                rd_val = st_q.val;
                hw_out = st_q.val;
            end
            ACC_STICKY: rd_val = st_q.val;
            ACC_PULSE:  hw_out = st_q.val;
            default:    rd_val = HW ? hw_in : RST;
        endcase
    end

    logic unused_field_ins;
    assign unused_field_ins = ^{wdata, hw_in, rd_hit, wr_hit};

    // Checks start one cycle after reset so $past never sees reset-time values.
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    if (ACC == ACC_STICKY) begin : g_chk_sticky
        a_r6_sticky_captures: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            (st_q.val & $past(hw_in)) == $past(hw_in));
        a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            !$past(rd_hit) |-> (st_q.val & $past(st_q.val)) == $past(st_q.val));
        a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            $past(rd_hit) |-> (st_q.val & ~$past(hw_in)) == '0);
    end
    if (ACC == ACC_PULSE) begin : g_chk_pulse
        a_r8_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            (|hw_out) |-> $past(wr_hit));
        a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            ((|hw_out) && !wr_hit) |=> !(|hw_out));
    end
    if (ACC == ACC_RW) begin : g_chk_rw
        a_r3_rw_takes_write: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            $past(wr_hit) |-> hw_out == $past(wdata));
        a_r3_rw_holds: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            !$past(wr_hit) |-> $stable(hw_out));
    end

endmodule

// File: rtl/frb_rdmux.sv
module frb_rdmux #(
    parameter int NREG = 4,
    parameter int AW   = 3,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] words [NREG],
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [DW-1:0] data;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d.data = '0;
        if (ren) begin
            for (int r = 0; r < NREG; r++) begin
                if (addr == AW'(r)) rd_d.data = words[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.data;

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        !$past(ren) |-> rdata == '0);
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(ren) && (int'($past(addr)) >= NREG)) |-> rdata == '0);

endmodule

// File: rtl/field_reg_bank.sv
module field_reg_bank
    import frb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ren,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [7:0]        status_in,
    input  logic [1:0]        event_in,
    output logic              core_hold,
    output logic [3:0]        gain,
    output logic              narrow_mode,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              irq
);

    logic [DATA_W-1:0]     fld_in  [NUM_FIELDS];
    logic [DATA_W-1:0]     fld_rd  [NUM_FIELDS];
    logic [DATA_W-1:0]     fld_out [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fld_irq;
    logic [DATA_W-1:0]     reg_word [NUM_REGS];

    // Hardware inputs routed to their fields.
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) fld_in[i] = '0;
        fld_in[3] = DATA_W'(status_in);
        fld_in[4] = DATA_W'(event_in[0]);
        fld_in[5] = DATA_W'(event_in[1]);
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        localparam fdesc_t              FD    = field_desc(i);
        localparam int                  FW    = int'(FD.width);
        localparam int                  LSB   = field_lsb(i);
        localparam logic [ADDR_W-1:0]   RADDR = ADDR_W'(FD.reg_idx);

        logic          wr_hit;
        logic          rd_hit;
        logic [FW-1:0] rd_val;
        logic [FW-1:0] hw_out;

        assign wr_hit = reg_wen && (reg_addr == RADDR);
        assign rd_hit = reg_ren && (reg_addr == RADDR);

        frb_field #(
            .ACC (FD.acc),
            .W   (FW),
            .RST (FD.rst[FW-1:0]),
            .HW  (FD.hw)
        ) i_field (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit),
            .rd_hit (rd_hit),
            .wdata  (reg_wdata[LSB +: FW]),
            .hw_in  (fld_in[i][FW-1:0]),
            .rd_val (rd_val),
            .hw_out (hw_out)
        );

        assign fld_rd[i]  = DATA_W'(rd_val) << LSB;
        assign fld_out[i] = DATA_W'(hw_out);
        assign fld_irq[i] = (FD.acc == ACC_STICKY && int'(FD.reg_idx) == IRQ_REG) ? |rd_val : 1'b0;
    end

    // Assemble register words from their positioned fields.
    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            reg_word[r] = '0;
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (int'(field_desc(i).reg_idx) == r) reg_word[r] = reg_word[r] | fld_rd[i];
            end
        end
    end

    frb_rdmux #(
        .NREG (NUM_REGS),
        .AW   (ADDR_W),
        .DW   (DATA_W)
    ) i_rdmux (
        .clk   (clk),
        .rst_n (rst_n),
        .ren   (reg_ren),
        .addr  (reg_addr),
        .words (reg_word),
        .rdata (reg_rdata)
    );

    assign irq         = |fld_irq;
    assign core_hold   = fld_out[1][0];
    assign gain        = fld_out[2][3:0];
    assign start_pulse = fld_out[6][0];
    assign stop_pulse  = fld_out[7][0];
    assign narrow_mode = fld_out[8][0];

    logic unused_fld_bits;
    always_comb begin
        unused_fld_bits = 1'b0;
        for (int i = 0; i < NUM_FIELDS; i++)
            unused_fld_bits = unused_fld_bits ^ (^fld_out[i]) ^ (^fld_in[i]);
    end

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r9_irq_after_event: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(|event_in) |-> irq);
    a_r9_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        (irq && !$past(irq)) |-> $past(|event_in));

endmodule

// File: tb/test_field_reg_bank.sv
module test_field_reg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ren = 1'b0;
    logic [31:0] reg_rdata;
    logic [7:0]  status_in = '0;
    logic [1:0]  event_in = '0;
    logic        core_hold, narrow_mode, start_pulse, stop_pulse, irq;
    logic [3:0]  gain;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    field_reg_bank i_field_reg_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_ren(reg_ren), .reg_rdata(reg_rdata),
        .status_in(status_in), .event_in(event_in), .core_hold(core_hold),
        .gain(gain), .narrow_mode(narrow_mode), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .irq(irq)
    );

    // Behavioural reference model.
    logic        m_hold, m_narrow, m_go, m_halt;
    logic [3:0]  m_gain;
    logic [1:0]  m_sticky;
    logic [31:0] m_rdata;

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] rv;
        if (!rst_n) begin
            m_hold = 1'b1; m_gain = 4'd5; m_narrow = 1'b0;
            m_go = 1'b0; m_halt = 1'b0; m_sticky = 2'b00; m_rdata = '0;
        end else begin
            case (reg_addr)
                3'd0:    rv = 32'h6169_616d;
                3'd1:    rv = (32'(status_in) << 5) | (32'(m_gain) << 1) | 32'(m_hold);
                3'd2:    rv = 32'(m_sticky);
                3'd3:    rv = 32'(m_narrow) << 2;
                default: rv = 32'd0;
            endcase
            m_rdata  = reg_ren ? rv : 32'd0;
            m_sticky = (reg_ren && reg_addr == 3'd2) ? event_in : (m_sticky | event_in);
            m_go = 1'b0;
            m_halt = 1'b0;
            if (reg_wen && reg_addr == 3'd1) begin
                m_hold = reg_wdata[0];
                m_gain = reg_wdata[4:1];
            end
            if (reg_wen && reg_addr == 3'd3) begin
                m_go     = reg_wdata[0];
                m_halt   = reg_wdata[1];
                m_narrow = reg_wdata[2];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 rdata", reg_rdata, m_rdata);
            chk("R3 hold", 32'(core_hold), 32'(m_hold));
            chk("R3 gain", 32'(gain), 32'(m_gain));
            chk("R3 narrow", 32'(narrow_mode), 32'(m_narrow));
            chk("R8 start", 32'(start_pulse), 32'(m_go));
            chk("R8 stop", 32'(stop_pulse), 32'(m_halt));
            chk("R9 irq", 32'(irq), 32'(|m_sticky));
        end
    end

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_ren = 1'b1;
        @(negedge clk);
        reg_ren = 1'b0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset values
        chk("R3 reset hold", 32'(core_hold), 32'd1);
        chk("R3 reset gain", 32'(gain), 32'd5);
        chk("R3 reset narrow", 32'(narrow_mode), 32'd0);
        chk("R9 reset irq", 32'(irq), 32'd0);
        chk("R2 reset rdata", reg_rdata, 32'd0);

        // R1 identification constant, R5 writes ignored
        do_rd(3'd0, 32'h6169_616d, "R1 id");
        do_wr(3'd0, 32'h0000_0000);
        do_rd(3'd0, 32'h6169_616d, "R5 id after write");

        // R4 packing with live status
        status_in = 8'hA5;
        do_rd(3'd1, 32'h0000_14AB, "R4 ctrl layout");
        do_wr(3'd1, 32'h0000_0000);
        chk("R3 hold written", 32'(core_hold), 32'd0);
        chk("R3 gain written", 32'(gain), 32'd0);
        do_wr(3'd1, 32'hFFFF_FFFF);
        status_in = 8'h3C;
        do_rd(3'd1, 32'h0000_079F, "R5 status ignores write");

        // R6 / R7 / R9 sticky events
        @(negedge clk); event_in = 2'b01;
        @(negedge clk); event_in = 2'b00;
        chk("R9 irq set", 32'(irq), 32'd1);
        repeat (3) @(negedge clk);
        chk("R6 held", 32'(irq), 32'd1);
        do_rd(3'd2, 32'd1, "R6 sticky read");
        chk("R7 cleared irq", 32'(irq), 32'd0);
        do_rd(3'd2, 32'd0, "R7 cleared");
        @(negedge clk); event_in = 2'b10;
        do_rd(3'd2, 32'd2, "R4 event1 bit");
        event_in = 2'b00;
        do_rd(3'd2, 32'd2, "R7 event same cycle kept");
        do_rd(3'd2, 32'd0, "R7 cleared after");

        // R8 command pulses
        do_wr(3'd3, 32'h0000_0003);
        chk("R8 start high", 32'(start_pulse), 32'd1);
        chk("R8 stop high", 32'(stop_pulse), 32'd1);
        @(negedge clk);
        chk("R8 start low", 32'(start_pulse), 32'd0);
        do_wr(3'd3, 32'h0000_0004);
        chk("R8 no pulse on 0", 32'(start_pulse), 32'd0);
        chk("R3 narrow set", 32'(narrow_mode), 32'd1);
        do_rd(3'd3, 32'h0000_0004, "R8 pulses read 0");

        // R10 unmapped
        do_wr(3'd5, 32'hFFFF_FFFF);
        do_wr(3'd7, 32'h0000_0000);
        do_rd(3'd5, 32'd0, "R10 unmapped 5");
        do_rd(3'd7, 32'd0, "R10 unmapped 7");
        chk("R10 outputs kept", {27'd0, gain, core_hold}, 32'h0000_001F);
        do_rd(3'd3, 32'h0000_0004, "R10 mode kept");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule